// File: doc/BRIEF.md
# Memory Wait-State Controller

This block is a small I/O register set through which the CPU sets how many wait cycles main-memory and video-memory accesses receive. It holds two wait counts and one readback byte. It also answers two identification ports that report the machine identifier and the CPU type code. The address of the wait register and the clamping rules that apply to a written value depend on the static machine identifier. One magic data value restores fixed defaults. The video wait always sits three cycles above the main wait.

A memory controller sends the block one request pulse per access, tagged as main RAM or VRAM. The block then holds `acc_ready` low for the latched number of wait cycles. A zero count gives ready in the request cycle itself. Every I/O read returns its data in the cycle after the read strobe.

Top module: `memwait_ctrl`

## Requirements
- R1: The wait register answers at port 0x05E0 when `machine_id` < 0x0200 and at port 0x05E2 otherwise. A write to the port that is not selected leaves both wait counts unchanged. A read of that port returns 0xFF.
- R2: Writing the low-id port takes n = data[2:0] and clamps it into 1..5. The main wait then becomes n+1, the video wait becomes n+4, and the readback byte becomes n.
- R3: Writing exactly 0x83 to the high-id port sets the main wait to 3 and the video wait to 6. The readback byte becomes 0x83.
- R4: Any other write to the high-id port takes n = data[2:0] and limits it to at most 5. If `machine_id` equals 0x0200, a result of 0 is raised to 1. The main wait then becomes n, the video wait becomes n+3, and the readback byte becomes n.
- R5: Reset (synchronous, active high) gives a main wait of 3, a video wait of 6, `io_rdata` = 0xFF and `acc_ready` = 1. The readback byte resets to 0x03 when `cpu_type` is 1 or 3, and to 0x83 otherwise.
- R6: A write to port 0x05EC takes effect only when `machine_id` >= 0x0500. With data bit 0 set, the waits become 0 (main) and 3 (video). With bit 0 clear, they become 3 and 6. The readback byte is not touched.
- R7: A read of port 0x0030 returns {machine_id[7:3], cpu_type[2:0]}. A read of port 0x0031 returns machine_id[15:8].
- R8: `io_rdata` carries the result of a read in the cycle after `io_rd`, and 0xFF in every other cycle. Unmapped ports, port 0x05EC and inactive ports all read as 0xFF.
- R9: A new wait count appears on `mem_wait` or `vram_wait` in the cycle after the write. Without a write, the counts do not change.
- R10: A request in cycle t whose selected count is N > 0 (VRAM count if `acc_vram`=1, else main count) drives `acc_ready` low in cycles t to t+N-1 and high in cycle t+N. When N = 0, `acc_ready` stays high in cycle t.
- R11: An access in progress keeps the count it latched at its start, even if a wait register is written while it runs. Requests that arrive while an access is in progress are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| machine_id | input | 16 | Static machine-model identifier |
| cpu_type | input | 3 | Static CPU type code |
| io_addr | input | 16 | I/O port address |
| io_wdata | input | 8 | I/O write data |
| io_wr | input | 1 | I/O write strobe, one cycle per write |
| io_rd | input | 1 | I/O read strobe, one cycle per read |
| io_rdata | output | 8 | Registered read data |
| mem_wait | output | 4 | Current main-memory wait count |
| vram_wait | output | 4 | Current video-memory wait count |
| acc_req | input | 1 | Access start pulse |
| acc_vram | input | 1 | Access tag: 1 = VRAM, 0 = main RAM |
| acc_ready | output | 1 | Access ready, low while wait cycles run |

## Verification
The checker assumes that `machine_id` and `cpu_type` are held constant between resets. It also assumes that `acc_req` is a start pulse for an access, not a level held for the length of the access. The stimulus changes the identifier and the CPU code only while `rst` is high, once per phase. Each request pulse lasts one cycle, except in one directed case that deliberately asserts a second request during a busy access to show that it is ignored.

// File: rtl/memwait_pkg.sv
package memwait_pkg;

  typedef enum logic [2:0] {
    PK_NONE,
    PK_WAIT_LO,
    PK_WAIT_HI,
    PK_FAST,
    PK_ID_A,
    PK_ID_B
  } port_kind_t;

  localparam logic [7:0] MAGIC_DEFAULT = 8'h83;
  localparam logic [7:0] RD_IDLE       = 8'hFF;

  function automatic logic [2:0] clamp_1_to_5(input logic [2:0] v);
    if (v == 3'd0)      return 3'd1;
    else if (v > 3'd5)  return 3'd5;
    else                return v;
  endfunction

  function automatic logic [2:0] clamp_to_5(input logic [2:0] v);
    return (v > 3'd5) ? 3'd5 : v;
  endfunction

endpackage

// File: rtl/memwait_decode.sv
module memwait_decode
  import memwait_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int ID_W   = 16,
  parameter logic [ADDR_W-1:0] P_WAIT_LO = 16'h05E0,
  parameter logic [ADDR_W-1:0] P_WAIT_HI = 16'h05E2,
  parameter logic [ADDR_W-1:0] P_FAST    = 16'h05EC,
  parameter logic [ADDR_W-1:0] P_ID_A    = 16'h0030,
  parameter logic [ADDR_W-1:0] P_ID_B    = 16'h0031,
  parameter logic [ID_W-1:0]   ID_SPLIT  = 16'h0200,
  parameter logic [ID_W-1:0]   ID_FAST   = 16'h0500
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ID_W-1:0]   id,
  output port_kind_t        kind
);
  logic hi_model;
  logic fast_ok;

  assign hi_model = (id >= ID_SPLIT);
  assign fast_ok  = (id >= ID_FAST);

  always_comb begin
    kind = PK_NONE;
    if (addr == P_ID_A)                       kind = PK_ID_A;
    else if (addr == P_ID_B)                  kind = PK_ID_B;
    else if (addr == P_WAIT_LO && !hi_model)  kind = PK_WAIT_LO;
    else if (addr == P_WAIT_HI && hi_model)   kind = PK_WAIT_HI;
    else if (addr == P_FAST && fast_ok)       kind = PK_FAST;
  end
endmodule

// File: rtl/memwait_regs.sv
module memwait_regs
  import memwait_pkg::*;
#(
  parameter int ID_W   = 16,
  parameter int CPU_W  = 3,
  parameter int WAIT_W = 4,
  parameter logic [ID_W-1:0] ID_CLAMP = 16'h0200
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ID_W-1:0]   id,
  input  logic [CPU_W-1:0]  cpu,
  input  port_kind_t        kind,
  input  logic              wr,
  input  logic [7:0]        wdata,
  output logic [WAIT_W-1:0] mem_wait,
  output logic [WAIT_W-1:0] vram_wait,
  output logic [7:0]        rb
);
  localparam logic [WAIT_W-1:0] DEF_MEM  = WAIT_W'(3);
  localparam logic [WAIT_W-1:0] DEF_VRAM = WAIT_W'(6);

  logic [2:0]        n_lo, n_hi;
  logic [WAIT_W-1:0] mem_nx, vram_nx;
  logic [7:0]        rb_nx;
  logic [7:0]        rb_reset;

  assign rb_reset = (cpu == CPU_W'(1) || cpu == CPU_W'(3)) ? 8'h03 : MAGIC_DEFAULT;

  always_comb begin
    n_lo = clamp_1_to_5(wdata[2:0]);
    n_hi = clamp_to_5(wdata[2:0]);
    if (id == ID_CLAMP && n_hi == 3'd0) n_hi = 3'd1;
  end

  always_comb begin
    mem_nx  = mem_wait;
    vram_nx = vram_wait;
    rb_nx   = rb;
    if (wr) begin
      unique case (kind)
        PK_WAIT_LO: begin
          mem_nx  = WAIT_W'(n_lo) + WAIT_W'(1);
          vram_nx = WAIT_W'(n_lo) + WAIT_W'(4);
          rb_nx   = {5'd0, n_lo};
        end
        PK_WAIT_HI: begin
          if (wdata == MAGIC_DEFAULT) begin
            mem_nx  = DEF_MEM;
            vram_nx = DEF_VRAM;
            rb_nx   = MAGIC_DEFAULT;
          end else begin
            mem_nx  = WAIT_W'(n_hi);
            vram_nx = WAIT_W'(n_hi) + WAIT_W'(3);
            rb_nx   = {5'd0, n_hi};
          end
        end
        PK_FAST: begin
          mem_nx  = wdata[0] ? WAIT_W'(0) : DEF_MEM;
          vram_nx = wdata[0] ? WAIT_W'(3) : DEF_VRAM;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_wait  <= DEF_MEM;
      vram_wait <= DEF_VRAM;
      rb        <= rb_reset;
    end else begin
      mem_wait  <= mem_nx;
      vram_wait <= vram_nx;
      rb        <= rb_nx;
    end
  end
endmodule

// File: rtl/memwait_rdmux.sv
module memwait_rdmux
  import memwait_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       rd,
  input  port_kind_t kind,
  input  logic [4:0] id_mid,
  input  logic [7:0] id_top,
  input  logic [2:0] cpu_lo,
  input  logic [7:0] rb,
  output logic [7:0] rdata
);
  logic [7:0] sel;

  always_comb begin
    unique case (kind)
      PK_ID_A:                sel = {id_mid, cpu_lo};
      PK_ID_B:                sel = id_top;
      PK_WAIT_LO, PK_WAIT_HI: sel = rb;
      default:                sel = RD_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= RD_IDLE;
    else if (rd) rdata <= sel;
    else         rdata <= RD_IDLE;
  end
endmodule

// File: rtl/memwait_seq.sv
module memwait_seq #(
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              is_vram,
  input  logic [WAIT_W-1:0] mem_wait,
  input  logic [WAIT_W-1:0] vram_wait,
  output logic              ready
);
  logic [WAIT_W-1:0] remain;
  logic [WAIT_W-1:0] pick;
  logic              idle;
  logic              start;

  assign pick  = is_vram ? vram_wait : mem_wait;
  assign idle  = (remain == '0);
  assign start = req && idle && (pick != '0);
  assign ready = idle && !start;

  always_ff @(posedge clk) begin
    if (rst)        remain <= '0;
    else if (start) remain <= pick - WAIT_W'(1);
    else if (!idle) remain <= remain - WAIT_W'(1);
  end
endmodule

// File: rtl/memwait_ctrl.sv
module memwait_ctrl
  import memwait_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int ID_W   = 16,
  parameter int CPU_W  = 3,
  parameter int WAIT_W = 4,
  parameter logic [ADDR_W-1:0] P_WAIT_LO = 16'h05E0,
  parameter logic [ADDR_W-1:0] P_WAIT_HI = 16'h05E2,
  parameter logic [ADDR_W-1:0] P_FAST    = 16'h05EC,
  parameter logic [ADDR_W-1:0] P_ID_A    = 16'h0030,
  parameter logic [ADDR_W-1:0] P_ID_B    = 16'h0031,
  parameter logic [ID_W-1:0]   ID_SPLIT  = 16'h0200,
  parameter logic [ID_W-1:0]   ID_FAST   = 16'h0500
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ID_W-1:0]   machine_id,
  input  logic [CPU_W-1:0]  cpu_type,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [7:0]        io_wdata,
  input  logic              io_wr,
  input  logic              io_rd,
  output logic [7:0]        io_rdata,
  output logic [WAIT_W-1:0] mem_wait,
  output logic [WAIT_W-1:0] vram_wait,
  input  logic              acc_req,
  input  logic              acc_vram,
  output logic              acc_ready
);
  port_kind_t kind;
  logic [7:0] rb;

  memwait_decode #(
    .ADDR_W(ADDR_W), .ID_W(ID_W),
    .P_WAIT_LO(P_WAIT_LO), .P_WAIT_HI(P_WAIT_HI), .P_FAST(P_FAST),
    .P_ID_A(P_ID_A), .P_ID_B(P_ID_B),
    .ID_SPLIT(ID_SPLIT), .ID_FAST(ID_FAST)
  ) u_dec (
    .addr(io_addr), .id(machine_id), .kind(kind)
  );

  memwait_regs #(
    .ID_W(ID_W), .CPU_W(CPU_W), .WAIT_W(WAIT_W), .ID_CLAMP(ID_SPLIT)
  ) u_regs (
    .clk(clk), .rst(rst), .id(machine_id), .cpu(cpu_type),
    .kind(kind), .wr(io_wr), .wdata(io_wdata),
    .mem_wait(mem_wait), .vram_wait(vram_wait), .rb(rb)
  );

  memwait_rdmux u_rd (
    .clk(clk), .rst(rst), .rd(io_rd), .kind(kind),
    .id_mid(machine_id[7:3]), .id_top(machine_id[ID_W-1 -: 8]),
    .cpu_lo(cpu_type[2:0]), .rb(rb), .rdata(io_rdata)
  );

  memwait_seq #(.WAIT_W(WAIT_W)) u_seq (
    .clk(clk), .rst(rst), .req(acc_req), .is_vram(acc_vram),
    .mem_wait(mem_wait), .vram_wait(vram_wait), .ready(acc_ready)
  );
endmodule

// File: rtl/memwait_chk.sv
module memwait_chk #(
  parameter int WAIT_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              io_wr,
  input logic              io_rd,
  input logic [7:0]        io_rdata,
  input logic [WAIT_W-1:0] mem_wait,
  input logic [WAIT_W-1:0] vram_wait,
  input logic              acc_req,
  input logic              acc_vram,
  input logic              acc_ready
);
  AST_RESET_WAITS: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mem_wait == WAIT_W'(3) && vram_wait == WAIT_W'(6))); // R5

  AST_VRAM_OFFSET: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (vram_wait == mem_wait + WAIT_W'(3))); // R2

  AST_MEM_LIMIT: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (mem_wait <= WAIT_W'(6))); // R4

  AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (rst)
    !$past(io_rd) |-> (io_rdata == 8'hFF)); // R8

  AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(io_wr)) |-> ($stable(mem_wait) && $stable(vram_wait))); // R9

  AST_START_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (acc_req && ((acc_vram && vram_wait != '0) || (!acc_vram && mem_wait != '0)))
      |-> !acc_ready); // R10

  AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(acc_ready) && !acc_req) |-> acc_ready); // R11
endmodule

bind memwait_ctrl memwait_chk #(.WAIT_W(WAIT_W)) u_chk (
  .clk(clk), .rst(rst), .io_wr(io_wr), .io_rd(io_rd), .io_rdata(io_rdata),
  .mem_wait(mem_wait), .vram_wait(vram_wait),
  .acc_req(acc_req), .acc_vram(acc_vram), .acc_ready(acc_ready)
);

// File: tb/sim_memwait_ctrl.sv
module sim_memwait_ctrl;
  timeunit 1ns;
  timeprecision 100ps;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] machine_id = 16'h0100;
  logic [2:0]  cpu_type = 3'd3;
  logic [15:0] io_addr = '0;
  logic [7:0]  io_wdata = '0;
  logic        io_wr = 1'b0;
  logic        io_rd = 1'b0;
  logic [7:0]  io_rdata;
  logic [3:0]  mem_wait, vram_wait;
  logic        acc_req = 1'b0;
  logic        acc_vram = 1'b0;
  logic        acc_ready;

  always #2.5 clk = ~clk;

  memwait_ctrl u0 (
    .clk(clk), .rst(rst), .machine_id(machine_id), .cpu_type(cpu_type),
    .io_addr(io_addr), .io_wdata(io_wdata), .io_wr(io_wr), .io_rd(io_rd),
    .io_rdata(io_rdata), .mem_wait(mem_wait), .vram_wait(vram_wait),
    .acc_req(acc_req), .acc_vram(acc_vram), .acc_ready(acc_ready)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  int m_mem, m_vram, m_rb;

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_mem = 3; m_vram = 6;
    m_rb = (cpu_type == 3'd1 || cpu_type == 3'd3) ? 8'h03 : 8'h83;
  endtask

  task automatic model_write(input logic [15:0] a, input logic [7:0] d);
    int n;
    n = int'(d[2:0]);
    if (a == 16'h05E0 && machine_id < 16'h0200) begin
      if (n < 1) n = 1;
      if (n > 5) n = 5;
      m_mem = n + 1; m_vram = n + 4; m_rb = n;
    end else if (a == 16'h05E2 && machine_id >= 16'h0200) begin
      if (d == 8'h83) begin
        m_mem = 3; m_vram = 6; m_rb = 8'h83;
      end else begin
        if (n > 5) n = 5;
        if (machine_id == 16'h0200 && n == 0) n = 1;
        m_mem = n; m_vram = n + 3; m_rb = n;
      end
    end else if (a == 16'h05EC && machine_id >= 16'h0500) begin
      m_mem  = d[0] ? 0 : 3;
      m_vram = d[0] ? 3 : 6;
    end
  endtask

  function automatic int model_read(input logic [15:0] a);
    if (a == 16'h0030) return int'({machine_id[7:3], cpu_type});
    if (a == 16'h0031) return int'(machine_id[15:8]);
    if (a == 16'h05E0 && machine_id < 16'h0200) return m_rb;
    if (a == 16'h05E2 && machine_id >= 16'h0200) return m_rb;
    return 8'hFF;
  endfunction

  task automatic do_write(input logic [15:0] a, input logic [7:0] d, input string tag);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
    model_write(a, d);
    check({tag, " mem_wait"}, int'(mem_wait), m_mem);
    check({tag, " vram_wait"}, int'(vram_wait), m_vram);
  endtask

  task automatic do_read(input logic [15:0] a, input string tag);
    io_addr = a; io_rd = 1'b1;
    @(negedge clk);
    io_rd = 1'b0;
    check({tag, " rdata"}, int'(io_rdata), model_read(a));
  endtask

  task automatic acc_test(input logic vr, input string tag);
    int n, cnt;
    n = vr ? m_vram : m_mem;
    acc_req = 1'b1; acc_vram = vr;
    #1;
    check({tag, " same-cycle ready"}, int'(acc_ready), (n == 0) ? 1 : 0);
    cnt = acc_ready ? 0 : 1;
    @(negedge clk);
    acc_req = 1'b0;
    while (!acc_ready && cnt < 40) begin
      cnt++;
      @(negedge clk);
    end
    check({tag, " low cycles"}, cnt, n);
    @(negedge clk);
    check({tag, " ready after access"}, int'(acc_ready), 1);
  endtask

  task automatic start_phase(input logic [15:0] id, input logic [2:0] cpu);
    rst = 1'b1; machine_id = id; cpu_type = cpu;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    model_reset();
    check("R5 mem_wait reset", int'(mem_wait), 3);
    check("R5 vram_wait reset", int'(vram_wait), 6);
    check("R5 rdata reset", int'(io_rdata), 8'hFF);
    check("R5 ready reset", int'(acc_ready), 1);
    do_read((id < 16'h0200) ? 16'h05E0 : 16'h05E2, "R5 readback reset");
  endtask

  task automatic random_ops(input int count);
    logic [15:0] addrs [6] = '{16'h05E0, 16'h05E2, 16'h05EC, 16'h0030, 16'h0031, 16'h0077};
    for (int i = 0; i < count; i++) begin
      logic [15:0] a;
      logic [7:0] d;
      a = addrs[$urandom % 6];
      d = ($urandom % 5 == 0) ? 8'h83 : 8'($urandom);
      if ($urandom % 2 == 0) do_write(a, d, "R9 random write");
      else                   do_read(a, "R8 random read");
      if (i % 10 == 9) acc_test(1'($urandom), "R10 random access");
    end
  endtask

  initial begin
    int cnt;
    void'($urandom(32'h5EED1234));
    @(negedge clk);

    // Low-id model, CPU code 3
    start_phase(16'h0100, 3'd3);
    do_write(16'h05E0, 8'h00, "R2 clamp low");
    check("R2 mem 0->1", int'(mem_wait), 2);
    do_write(16'h05E0, 8'hF7, "R2 clamp high");
    check("R2 vram 7->5", int'(vram_wait), 9);
    do_write(16'h05E0, 8'h03, "R2 mid value");
    do_read(16'h05E0, "R2 readback");
    do_write(16'h05E2, 8'h01, "R1 inactive port write");
    do_read(16'h05E2, "R1 inactive port read");
    do_write(16'h05EC, 8'h01, "R6 write below id limit");
    acc_test(1'b0, "R10 main");
    acc_test(1'b1, "R10 vram");
    check("R8 idle rdata", int'(io_rdata), 8'hFF);
    random_ops(40);

    // Id exactly at the split, CPU code 0
    start_phase(16'h0200, 3'd0);
    do_write(16'h05E2, 8'h00, "R4 raise to 1");
    check("R4 mem at split", int'(mem_wait), 1);
    do_write(16'h05E2, 8'h83, "R3 magic");
    do_read(16'h05E2, "R3 readback");
    do_write(16'h05E2, 8'h0E, "R4 limit 6->5");
    do_write(16'h05E0, 8'h01, "R1 inactive low port");
    do_read(16'h05E0, "R1 inactive low read");
    do_read(16'h0030, "R7 id port A");
    do_read(16'h0031, "R7 id port B");
    random_ops(40);

    // Id above the split, CPU code 1
    start_phase(16'h0300, 3'd1);
    do_write(16'h05E2, 8'h08, "R4 zero allowed");
    check("R4 mem zero", int'(mem_wait), 0);
    acc_test(1'b0, "R10 zero wait");
    acc_test(1'b1, "R10 vram 3");
    do_write(16'h05E2, 8'h83, "R3 magic again");
    random_ops(40);

    // Id with the fast register, CPU code 5
    start_phase(16'h0A37, 3'd5);
    do_write(16'h05EC, 8'h01, "R6 fast set");
    do_read(16'h05E2, "R6 readback untouched");
    do_write(16'h05EC, 8'hFE, "R6 fast clear");
    do_read(16'h05EC, "R8 fast port read");
    do_read(16'h0030, "R7 id port A hi");
    do_read(16'h0031, "R7 id port B hi");

    // R11: latched count during a write and a second request
    acc_req = 1'b1; acc_vram = 1'b1;
    #1;
    cnt = acc_ready ? 0 : 1;
    @(negedge clk);
    io_addr = 16'h05EC; io_wdata = 8'h01; io_wr = 1'b1;
    cnt = cnt + (acc_ready ? 0 : 1);
    @(negedge clk);
    io_wr = 1'b0; acc_req = 1'b0;
    model_write(16'h05EC, 8'h01);
    while (!acc_ready && cnt < 40) begin
      cnt++;
      @(negedge clk);
    end
    check("R11 latched vram count", cnt, 6);
    @(negedge clk);
    check("R11 second request ignored", int'(acc_ready), 1);
    check("R9 mem after busy write", int'(mem_wait), 0);
    acc_test(1'b1, "R11 new count used");
    random_ops(40);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule